// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Controller

This block sequences one conversion of a successive-approximation analog-to-digital converter. A start request captures the configuration: resolution, sample-and-hold length and input channel. The block then holds the selected input in a sample phase of a programmable length. After that it runs a binary search, most significant bit first, and drives a trial code to an external DAC and comparator. The single comparator decision comes back on one input line. At the end the block presents the code right-justified in a 12-bit result, together with a one-cycle done pulse.

The conversion phase, which follows the sample phase, always lasts the resolution in bits plus two clock cycles. One cycle prepares the first trial. One cycle is spent on each bit. The last cycle stores the result. The trial code is always left-justified on the 12-bit DAC scale, so the analog side sees the same full-scale range at every resolution. Configuration inputs are read only when a start is accepted. A start that arrives during a conversion is dropped.

Top module: `sar_adc_ctrl`

## Requirements
- R1: Resolution code on `cfg_res`: 2'b00 selects 8 bits, 2'b01 selects 10 bits, 2'b10 and 2'b11 select 12 bits. The result equals the N-bit code of the binary search. It is right-justified and zero-extended to 12 bits, which for an input level V on a 12-bit scale is V >> (12 − N).
- R2: While reset is asserted and after it is released, `busy`, `done`, `sample_en`, `result`, `chan_sel` and `trial_code` are zero. `res_active` reads 2'b01, the 10-bit setting.
- R3: `sample_en` is high for exactly H cycles, starting in the cycle after the edge that accepts a start. H comes from the 4-bit `cfg_hold` code as follows: 0→4, 1→8, 2→16, 3→32, 4→64, 5→96, 6→128, 7→192, 8→256, 9→384, 10→512, 11 and 12→768, 13 to 15→1024.
- R4: `done` rises exactly H + N + 2 cycles after the accepting edge and stays high for a single cycle. `busy` is high from the accepting edge until `done` rises, which is H + N + 2 cycles. `result` changes only in the cycle in which `done` is high.
- R5: The search starts at the most significant bit. In the first trial cycle `trial_code` is 12'h800. Each tested bit is kept when `cmp_in` is 1, meaning the input is at or above the trial level, and cleared when it is 0. The trial code is left-justified, so its low 12 − N bits are zero.
- R6: A start is accepted only while `busy` is low. A start during a conversion, and any change of the configuration inputs during it, has no effect on the timing, the result, `res_active` or `chan_sel` of that conversion.
- R7: `chan_sel` presents the channel number (0 to 15) taken from `cfg_chan` at the accepting edge, and holds it until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Conversion request, sampled while idle |
| cfg_res | input | 2 | Resolution code (see R1) |
| cfg_hold | input | 4 | Sample-phase length code (see R3) |
| cfg_chan | input | CHAN_W (4) | Input channel number |
| cmp_in | input | 1 | Comparator decision: 1 = input at or above trial level |
| sample_en | output | 1 | Sample-and-hold switch closed |
| chan_sel | output | CHAN_W (4) | Latched channel number for the input multiplexer |
| trial_code | output | 12 | Left-justified code for the DAC |
| res_active | output | 2 | Resolution code of the current or last conversion |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse with a new result |
| result | output | 12 | Right-justified conversion result |

## Verification
Every result of this block is due at a fixed cycle that can be computed from the accepting edge. Counting that edge as index 0, `sample_en` is high at indices 0 to H−1, the first trial code appears at index H+1, and `done` and the new `result` appear at index H+N+2. The bench drives inputs and samples outputs at the falling clock edge. At every falling edge after a start it records the index at which each output is active, then compares those indices and totals with the values it computes from the requirement's formulas. The checker module adds per-cycle properties: `done` is one cycle wide, `busy` falls only together with `done`, the configuration stays stable during a conversion, and the trial code keeps its alignment.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

  localparam int unsigned RES_MAX = 12;
  localparam int unsigned RB_W    = $clog2(RES_MAX + 1);
  localparam int unsigned RCODE_W = 2;
  localparam int unsigned SHT_W   = 4;
  localparam int unsigned CNT_W   = 11;

  localparam logic [RCODE_W-1:0] RCODE_8  = 2'd0;
  localparam logic [RCODE_W-1:0] RCODE_10 = 2'd1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_SETUP,
    ST_TRIAL,
    ST_LATCH
  } conv_state_e;

  // Resolution code to number of bits; both upper codes give full width.
  function automatic logic [RB_W-1:0] res_width(input logic [RCODE_W-1:0] rcode);
    case (rcode)
      RCODE_8:  return RB_W'(8);
      RCODE_10: return RB_W'(10);
      default:  return RB_W'(RES_MAX);
    endcase
  endfunction

  // Sample-phase length in clock cycles for each hold code.
  function automatic logic [CNT_W-1:0] hold_cycles(input logic [SHT_W-1:0] code);
    case (code)
      4'd0:    return CNT_W'(4);
      4'd1:    return CNT_W'(8);
      4'd2:    return CNT_W'(16);
      4'd3:    return CNT_W'(32);
      4'd4:    return CNT_W'(64);
      4'd5:    return CNT_W'(96);
      4'd6:    return CNT_W'(128);
      4'd7:    return CNT_W'(192);
      4'd8:    return CNT_W'(256);
      4'd9:    return CNT_W'(384);
      4'd10:   return CNT_W'(512);
      4'd11,
      4'd12:   return CNT_W'(768);
      default: return CNT_W'(1024);
    endcase
  endfunction

endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/sar_hold_timer.sv
module sar_hold_timer #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_len,
  input  logic             run,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expire = (cnt_q == '0);

  always_comb begin
    cnt_en = load | (run & ~expire);
    if (load) cnt_d = load_len - CNT_W'(1);
    else      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sar_search_engine.sv
module sar_search_engine #(
  parameter int unsigned RES_MAX = 12,
  parameter int unsigned RB_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               arm,
  input  logic               step,
  input  logic               cmp_in,
  input  logic [RB_W-1:0]    res_n,
  output logic [RES_MAX-1:0] code,
  output logic               last,
  output logic [RES_MAX-1:0] trial
);

  logic [RES_MAX-1:0] code_q, code_d;
  logic [RES_MAX-1:0] mask_q, mask_d;
  logic               reg_en;

  always_comb begin
    reg_en = clear | arm | step;
    code_d = code_q;
    mask_d = mask_q;
    if (clear) begin
      code_d = '0;
      mask_d = '0;
    end else if (arm) begin
      mask_d = RES_MAX'(1) << (res_n - RB_W'(1));
      code_d = mask_d;
    end else if (step) begin
      code_d = (cmp_in ? code_q : (code_q & ~mask_q)) | (mask_q >> 1);
      mask_d = mask_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mask_q <= '0;
    end else if (reg_en) begin
      code_q <= code_d;
      mask_q <= mask_d;
    end
  end

  assign code  = code_q;
  assign last  = mask_q[0];
  assign trial = code_q << (RB_W'(RES_MAX) - res_n);

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int unsigned CHAN_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [RCODE_W-1:0] cfg_res,
  input  logic [SHT_W-1:0]   cfg_hold,
  input  logic [CHAN_W-1:0]  cfg_chan,
  input  logic               cmp_in,
  output logic               sample_en,
  output logic [CHAN_W-1:0]  chan_sel,
  output logic [RES_MAX-1:0] trial_code,
  output logic [RCODE_W-1:0] res_active,
  output logic               busy,
  output logic               done,
  output logic [RES_MAX-1:0] result
);

  logic               rst_n_int;
  conv_state_e        state_q, state_d;
  logic               accept;
  logic               hold_expire;
  logic               srch_last;
  logic [RES_MAX-1:0] srch_code;
  logic [RCODE_W-1:0] res_q;
  logic [CHAN_W-1:0]  chan_q;
  logic [RES_MAX-1:0] result_q;
  logic               done_q;
  logic [RB_W-1:0]    res_n;

  sar_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  assign accept = (state_q == ST_IDLE) & start;
  assign res_n  = res_width(res_q);

  sar_hold_timer #(.CNT_W(CNT_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (accept),
    .load_len (hold_cycles(cfg_hold)),
    .run      (state_q == ST_SAMPLE),
    .expire   (hold_expire)
  );

  sar_search_engine #(.RES_MAX(RES_MAX), .RB_W(RB_W)) u_search (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .clear  (accept),
    .arm    (state_q == ST_SETUP),
    .step   (state_q == ST_TRIAL),
    .cmp_in (cmp_in),
    .res_n  (res_n),
    .code   (srch_code),
    .last   (srch_last),
    .trial  (trial_code)
  );

  // Sequencer next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start)       state_d = ST_SAMPLE;
      ST_SAMPLE: if (hold_expire) state_d = ST_SETUP;
      ST_SETUP:                   state_d = ST_TRIAL;
      ST_TRIAL:  if (srch_last)   state_d = ST_LATCH;
      ST_LATCH:                   state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  // Configuration capture, only on an accepted start
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      res_q  <= RCODE_10;
      chan_q <= '0;
    end else if (accept) begin
      res_q  <= cfg_res;
      chan_q <= cfg_chan;
    end
  end

  // Result store and completion pulse
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= (state_q == ST_LATCH);
      if (state_q == ST_LATCH) result_q <= srch_code;
    end
  end

  assign sample_en  = (state_q == ST_SAMPLE);
  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign result     = result_q;
  assign res_active = res_q;
  assign chan_sel   = chan_q;

endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk
  import sar_adc_pkg::*;
#(
  parameter int unsigned CHAN_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sample_en,
  input logic [CHAN_W-1:0]  chan_sel,
  input logic [RES_MAX-1:0] trial_code,
  input logic [RCODE_W-1:0] res_active,
  input logic               busy,
  input logic               done,
  input logic [RES_MAX-1:0] result
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R4

  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);  // R4

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));  // R4

  AST_SAMPLE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> busy);  // R3

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(res_active) && $stable(chan_sel)));  // R6

  AST_NARROW_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_active == RCODE_8) |-> (result[RES_MAX-1:8] == '0));  // R1

  AST_TRIAL_LEFT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && res_active == RCODE_8) |-> (trial_code[3:0] == 4'd0));  // R5

endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.CHAN_W(CHAN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_en  (sample_en),
  .chan_sel   (chan_sel),
  .trial_code (trial_code),
  .res_active (res_active),
  .busy       (busy),
  .done       (done),
  .result     (result)
);

// File: tb/tb_sar_adc_ctrl.sv
module tb_sar_adc_ctrl;

  typedef struct packed {
    logic [1:0]  res;
    logic [3:0]  hold;
    logic [3:0]  chan;
    logic [11:0] vin;
  } vec_t;

  localparam int N_VEC = 8;
  localparam vec_t VEC [N_VEC] = '{
    '{2'd1, 4'd0, 4'd0,  12'h5A3},
    '{2'd0, 4'd1, 4'd12, 12'hFFF},
    '{2'd2, 4'd2, 4'd13, 12'h000},
    '{2'd2, 4'd3, 4'd5,  12'h800},
    '{2'd0, 4'd0, 4'd15, 12'h0FF},
    '{2'd3, 4'd4, 4'd3,  12'h7FF},
    '{2'd1, 4'd5, 4'd1,  12'hFFF},
    '{2'd2, 4'd0, 4'd7,  12'h001}
  };

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [1:0]  cfg_res;
  logic [3:0]  cfg_hold;
  logic [3:0]  cfg_chan;
  logic        cmp_in;
  logic        sample_en;
  logic [3:0]  chan_sel;
  logic [11:0] trial_code;
  logic [1:0]  res_active;
  logic        busy;
  logic        done;
  logic [11:0] result;
  logic [11:0] vin;

  int n_chk;
  int n_bad;

  sar_adc_ctrl dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cfg_res    (cfg_res),
    .cfg_hold   (cfg_hold),
    .cfg_chan   (cfg_chan),
    .cmp_in     (cmp_in),
    .sample_en  (sample_en),
    .chan_sel   (chan_sel),
    .trial_code (trial_code),
    .res_active (res_active),
    .busy       (busy),
    .done       (done),
    .result     (result)
  );

  // Comparator model: input level at or above the DAC level gives 1.
  assign cmp_in = (vin >= trial_code);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int exp_bits(input logic [1:0] r);
    case (r)
      2'd0:    return 8;
      2'd1:    return 10;
      default: return 12;
    endcase
  endfunction

  function automatic int exp_hold(input logic [3:0] c);
    case (c)
      4'd0:  return 4;
      4'd1:  return 8;
      4'd2:  return 16;
      4'd3:  return 32;
      4'd4:  return 64;
      4'd5:  return 96;
      4'd6:  return 128;
      4'd7:  return 192;
      4'd8:  return 256;
      4'd9:  return 384;
      4'd10: return 512;
      4'd11: return 768;
      4'd12: return 768;
      default: return 1024;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R2 busy in reset", int'(busy), 0);
    chk("R2 done in reset", int'(done), 0);
    chk("R2 sample_en in reset", int'(sample_en), 0);
    chk("R2 result in reset", int'(result), 0);
    chk("R2 chan_sel in reset", int'(chan_sel), 0);
    chk("R2 trial_code in reset", int'(trial_code), 0);
    chk("R2 res_active default 10-bit", int'(res_active), 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 busy after release", int'(busy), 0);
    chk("R2 res_active after release", int'(res_active), 1);
  endtask

  // One conversion; index 0 is the falling edge after the accepting edge.
  task automatic run_conv(input vec_t v, input bit disturb, input string tag);
    int hold_n = exp_hold(v.hold);
    int rb     = exp_bits(v.res);
    int total  = hold_n + rb + 2;
    int s_cnt  = 0;
    int b_cnt  = 0;
    int d_cnt  = 0;
    int d_idx  = -1;
    int trial_first = 0;
    @(negedge clk);
    cfg_res  = v.res;
    cfg_hold = v.hold;
    cfg_chan = v.chan;
    vin      = v.vin;
    start    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int idx = 0; idx <= total + 1; idx++) begin
      if (sample_en) s_cnt++;
      if (busy) b_cnt++;
      if (done) begin
        d_cnt++;
        if (d_idx < 0) d_idx = idx;
      end
      if (idx == hold_n + 1) trial_first = int'(trial_code);
      if (disturb && idx == 2) begin
        start    = 1'b1;
        cfg_res  = ~v.res;
        cfg_chan = ~v.chan;
        cfg_hold = ~v.hold;
      end
      if (disturb && idx == 3) start = 1'b0;
      @(posedge clk);
      @(negedge clk);
    end
    chk({"R1 result ", tag}, int'(result), int'(v.vin >> (12 - rb)));
    chk({"R3 sample length ", tag}, s_cnt, hold_n);
    chk({"R4 done index ", tag}, d_idx, total);
    chk({"R4 done width ", tag}, d_cnt, 1);
    chk({"R4 busy length ", tag}, b_cnt, total);
    chk({"R5 first trial code ", tag}, trial_first, 32'h800);
    chk({"R6 res_active ", tag}, int'(res_active), int'(v.res));
    chk({"R7 chan_sel ", tag}, int'(chan_sel), int'(v.chan));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    vec_t dv;
    n_chk    = 0;
    n_bad    = 0;
    rst_n    = 1'b0;
    start    = 1'b0;
    cfg_res  = 2'd0;
    cfg_hold = 4'd0;
    cfg_chan = 4'd0;
    vin      = 12'd0;

    apply_reset();

    // Table of vectors: R1 R3 R4 R5 R6 R7
    for (int i = 0; i < N_VEC; i++) begin
      run_conv(VEC[i], 1'b0, $sformatf("vec%0d", i));
    end

    // Every hold code (R3), 8-bit mode zero extension (R1)
    for (int c = 0; c < 16; c++) begin
      dv = '{2'd0, 4'(c), 4'(c), 12'h123};
      run_conv(dv, 1'b0, $sformatf("hold%0d", c));
    end

    // Start and configuration changes while busy are ignored (R6)
    dv = '{2'd2, 4'd1, 4'd9, 12'hA5C};
    run_conv(dv, 1'b1, "r6_busy_start");
    dv = '{2'd0, 4'd0, 4'd14, 12'h3F0};
    run_conv(dv, 1'b1, "r6_busy_start_8b");

    // Comparator ties: level exactly on a trial boundary (R5)
    dv = '{2'd1, 4'd0, 4'd2, 12'h004};
    run_conv(dv, 1'b0, "r5_boundary");

    // Reset in the middle of a conversion (R2)
    @(negedge clk);
    cfg_res  = 2'd2;
    cfg_hold = 4'd3;
    cfg_chan = 4'd11;
    vin      = 12'h777;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2 busy before mid reset", int'(busy), 1);
    apply_reset();

    summary();
    $finish;
  end

endmodule